// File: doc/BRIEF.md
# Processor Status Word with Condition Flag Update

This block keeps the 32-bit status word of a small 32-bit processor core. The word has three parts. The top four bits hold the arithmetic condition flags. A six-bit field holds the number of the exception the core is currently servicing. A single bit records the execution state.

On each flag write the block takes the following inputs:

- the ALU result;
- the adder carry or borrow output;
- a shifter carry-out;
- the sign bits of both operands;
- an operation-class code.

From these it works out the four condition flags. It then changes only the flags that the given operation class is allowed to touch.

On exception entry and exit, the exception field is loaded with a new number. Zero means thread mode. An issue strobe marks each instruction as it starts to execute. If that strobe arrives while the execution-state bit is clear, the block raises a fault request on the next cycle.

The flag-write enable, the exception load and the state-bit write are independent. Any mix of them can occur in the same cycle.

Top module: `psr_unit`

## Requirements
- R1: While reset is held, and after it is released, `psr_o` reads 0x0100_0000 (only the state bit at bit 24 is set) and `fault_req_o` is 0.
- R2: On a flag write with an updating class (codes 0 to 4), N at bit 31 takes `result_i[31]`, and Z at bit 30 is set exactly when `result_i` is zero. The new values appear on the next rising clock edge.
- R3: For class 0 (add), C at bit 29 takes `alu_cout_i`, the unsigned carry-out. V at bit 28 is set when both operand sign bits are equal and the result sign differs from them.
- R4: For class 1 (subtract or compare), `alu_cout_i` is the borrow output and C takes its inverse, so C is 1 when there is no borrow. V is set when the operand sign bits differ and the result sign differs from that of operand a.
- R5: For class 2 (multiply) and class 3 (logical or move), C and V keep their previous values.
- R6: For class 4 (shift), C takes `shift_cout_i` and V keeps its previous value.
- R7: When `flag_we_i` is 0, or the class code is 5, 6 or 7, none of the four flags changes.
- R8: When `exc_load_i` is 1, bits [5:0] take `exc_num_i` on the next edge. Otherwise they hold their value.
- R9: When `state_we_i` is 1, bit 24 takes `state_bit_i` on the next edge. Otherwise it holds its value.
- R10: `fault_req_o` is 1 for the cycle after an edge at which `instr_issue_i` was 1 while bit 24 was 0. In every other cycle it is 0.
- R11: Bits [27:25] and [23:6] always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_we_i | input | 1 | Flag write enable |
| op_class_i | input | 3 | Operation class: 0 add, 1 sub, 2 mul, 3 logic, 4 shift, 5-7 none |
| result_i | input | 32 | ALU result |
| alu_cout_i | input | 1 | Adder carry (add) or borrow (sub) |
| shift_cout_i | input | 1 | Shifter carry-out |
| opa_msb_i | input | 1 | Sign bit of operand a |
| opb_msb_i | input | 1 | Sign bit of operand b |
| exc_load_i | input | 1 | Load exception number |
| exc_num_i | input | 6 | Exception number to load |
| state_we_i | input | 1 | Execution-state bit write enable |
| state_bit_i | input | 1 | Execution-state bit value |
| instr_issue_i | input | 1 | An instruction starts executing |
| psr_o | output | 32 | Status word |
| fault_req_o | output | 1 | Fault request for a clear state bit |

## Verification
Two kinds of same-cycle overlap matter here. A flag write can coincide with an exception-number load, and a state-bit write can coincide with an instruction issue. The random phase drives all four strobes independently every cycle, so each field's update is checked while the others are changing.

In the issue-and-write case, the check expects the fault decision to use the state bit as it was before the edge, not the value being written. Directed cases force both coincidences explicitly: clearing the bit in the same cycle as an issue gives no fault, and the following issue does give one.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EXC_W  = 6;
  localparam int unsigned T_POS  = 24;
  localparam int unsigned NFLAG  = 4;

  // flag index inside the 4-bit group, matches [31:28]
  localparam int unsigned F_V = 0;
  localparam int unsigned F_C = 1;
  localparam int unsigned F_Z = 2;
  localparam int unsigned F_N = 3;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_SUB   = 3'd1,
    OPC_MUL   = 3'd2,
    OPC_LOGIC = 3'd3,
    OPC_SHIFT = 3'd4
  } op_class_e;
endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [2:0]       op_class_i,
  input  logic [W-1:0]     result_i,
  input  logic             alu_cout_i,
  input  logic             shift_cout_i,
  input  logic             opa_msb_i,
  input  logic             opb_msb_i,
  output logic [NFLAG-1:0] flag_nxt_o,
  output logic [NFLAG-1:0] upd_mask_o
);
  logic r_msb;
  logic ovf_add, ovf_sub;

  assign r_msb   = result_i[W-1];
  assign ovf_add = (opa_msb_i == opb_msb_i) && (r_msb != opa_msb_i);
  assign ovf_sub = (opa_msb_i != opb_msb_i) && (r_msb != opa_msb_i);

  always_comb begin
    flag_nxt_o        = '0;
    flag_nxt_o[F_N]   = r_msb;
    flag_nxt_o[F_Z]   = ~|result_i;
    upd_mask_o        = '0;
    unique case (op_class_i)
      OPC_ADD: begin
        flag_nxt_o[F_C] = alu_cout_i;
        flag_nxt_o[F_V] = ovf_add;
        upd_mask_o      = '1;
      end
      OPC_SUB: begin
        flag_nxt_o[F_C] = ~alu_cout_i;  // carry = not borrow
        flag_nxt_o[F_V] = ovf_sub;
        upd_mask_o      = '1;
      end
      OPC_MUL, OPC_LOGIC: begin
        upd_mask_o[F_N] = 1'b1;
        upd_mask_o[F_Z] = 1'b1;
      end
      OPC_SHIFT: begin
        flag_nxt_o[F_C] = shift_cout_i;
        upd_mask_o[F_N] = 1'b1;
        upd_mask_o[F_Z] = 1'b1;
        upd_mask_o[F_C] = 1'b1;
      end
      default: upd_mask_o = '0;
    endcase
  end
endmodule

// File: rtl/psr_exc_field.sv
module psr_exc_field #(
  parameter int unsigned EW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [EW-1:0] num_i,
  output logic [EW-1:0] num_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     num_o <= '0;
    else if (load_i) num_o <= num_i;
  end
endmodule

// File: rtl/psr_state_ctl.sv
module psr_state_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic bit_i,
  input  logic issue_i,
  output logic state_o,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= 1'b1;
      fault_o <= 1'b0;
    end else begin
      if (we_i) state_o <= bit_i;
      // fault judged on the state held before this edge
      fault_o <= issue_i & ~state_o;
    end
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic [2:0]        op_class_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              alu_cout_i,
  input  logic              shift_cout_i,
  input  logic              opa_msb_i,
  input  logic              opb_msb_i,
  input  logic              exc_load_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  input  logic              state_we_i,
  input  logic              state_bit_i,
  input  logic              instr_issue_i,
  output logic [DATA_W-1:0] psr_o,
  output logic              fault_req_o
);
  logic [NFLAG-1:0] flag_nxt, upd_mask, flag_q;
  logic [EXC_W-1:0] exc_q;
  logic             state_q;

  psr_flag_calc #(.W(DATA_W)) i_calc (
    .op_class_i  (op_class_i),
    .result_i    (result_i),
    .alu_cout_i  (alu_cout_i),
    .shift_cout_i(shift_cout_i),
    .opa_msb_i   (opa_msb_i),
    .opb_msb_i   (opb_msb_i),
    .flag_nxt_o  (flag_nxt),
    .upd_mask_o  (upd_mask)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_q[g] <= 1'b0;
      else if (flag_we_i && upd_mask[g]) flag_q[g] <= flag_nxt[g];
    end
  end

  psr_exc_field #(.EW(EXC_W)) i_exc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(exc_load_i),
    .num_i (exc_num_i),
    .num_o (exc_q)
  );

  psr_state_ctl i_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (state_we_i),
    .bit_i  (state_bit_i),
    .issue_i(instr_issue_i),
    .state_o(state_q),
    .fault_o(fault_req_o)
  );

  always_comb begin
    psr_o                          = '0;
    psr_o[DATA_W-1 -: NFLAG]       = flag_q;
    psr_o[T_POS]                   = state_q;
    psr_o[EXC_W-1:0]               = exc_q;
  end
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flag_we_i,
  input logic [2:0]  op_class_i,
  input logic [31:0] result_i,
  input logic        exc_load_i,
  input logic [5:0]  exc_num_i,
  input logic        instr_issue_i,
  input logic [31:0] psr_o,
  input logic        fault_req_o
);
  a_r11_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_o[27:25] == 3'b0 && psr_o[23:6] == 18'b0);

  a_r7_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i || op_class_i > 3'd4) |=> $stable(psr_o[31:28]));

  a_r5_mul_keeps_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_class_i == 3'd2 || op_class_i == 3'd3)) |=> $stable(psr_o[29:28]));

  a_r2_zero_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_class_i <= 3'd4 && result_i == 32'd0) |=> psr_o[30]);

  a_r8_exc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_load_i |=> psr_o[5:0] == $past(exc_num_i));

  a_r10_fault_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_issue_i && !psr_o[24]) |=> fault_req_o);

  a_r10_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_issue_i && !psr_o[24]) |=> !fault_req_o);
endmodule

bind psr_unit psr_unit_chk i_psr_unit_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flag_we_i    (flag_we_i),
  .op_class_i   (op_class_i),
  .result_i     (result_i),
  .exc_load_i   (exc_load_i),
  .exc_num_i    (exc_num_i),
  .instr_issue_i(instr_issue_i),
  .psr_o        (psr_o),
  .fault_req_o  (fault_req_o)
);

// File: tb/test_psr_unit.sv
module test_psr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flag_we_i = 1'b0;
  logic [2:0]  op_class_i = 3'd0;
  logic [31:0] result_i = '0;
  logic        alu_cout_i = 1'b0;
  logic        shift_cout_i = 1'b0;
  logic        opa_msb_i = 1'b0;
  logic        opb_msb_i = 1'b0;
  logic        exc_load_i = 1'b0;
  logic [5:0]  exc_num_i = '0;
  logic        state_we_i = 1'b0;
  logic        state_bit_i = 1'b0;
  logic        instr_issue_i = 1'b0;
  logic [31:0] psr_o;
  logic        fault_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] e_flg;
  logic [5:0] e_exc;
  logic       e_t;
  logic       e_flt;

  always #2.5 clk_i = ~clk_i;

  psr_unit i_psr_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3 add";
      3'd1: return "R4 sub";
      3'd2, 3'd3: return "R5 mul/logic";
      3'd4: return "R6 shift";
      default: return "R7 no-class";
    endcase
  endfunction

  // expected flags {N,Z,C,V} after one edge
  function automatic logic [3:0] nxt_flags(input logic [3:0] cur, input logic we,
      input logic [2:0] op, input logic [31:0] r, input logic co, input logic sc,
      input logic a, input logic b);
    logic [3:0] f;
    f = cur;
    if (we && op <= 3'd4) begin
      f[3] = r[31];
      f[2] = (r == 32'd0);
      if (op == 3'd0) begin f[1] = co;  f[0] = (a == b) && (r[31] != a); end
      if (op == 3'd1) begin f[1] = !co; f[0] = (a != b) && (r[31] != a); end
      if (op == 3'd4) f[1] = sc;
    end
    return f;
  endfunction

  // drive at negedge, model update, check just after the edge
  task automatic step(input logic we, input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] rr, input logic sc, input logic el,
      input logic [5:0] en, input logic swe, input logic sb, input logic iss);
    logic [31:0] r;
    logic co;
    @(negedge clk_i);
    r = rr; co = 1'b0;
    if (op == 3'd0) {co, r} = {1'b0, a} + {1'b0, b};
    if (op == 3'd1) begin r = a - b; co = (a < b); end
    flag_we_i = we; op_class_i = op; result_i = r; alu_cout_i = co;
    shift_cout_i = sc; opa_msb_i = a[31]; opb_msb_i = b[31];
    exc_load_i = el; exc_num_i = en; state_we_i = swe; state_bit_i = sb;
    instr_issue_i = iss;
    e_flt = iss && !e_t;
    e_flg = nxt_flags(e_flg, we, op, r, co, sc, a[31], b[31]);
    if (el) e_exc = en;
    if (swe) e_t = sb;
    @(posedge clk_i);
    #1;
    if (we) chk({tag_of(op), " flags"}, {28'd0, psr_o[31:28]}, {28'd0, e_flg});
    else    chk("R7 we low flags", {28'd0, psr_o[31:28]}, {28'd0, e_flg});
    chk("R2 N", {31'd0, psr_o[31]}, {31'd0, e_flg[3]});
    chk("R8 exc", {26'd0, psr_o[5:0]}, {26'd0, e_exc});
    chk("R9 state", {31'd0, psr_o[24]}, {31'd0, e_t});
    chk("R10 fault", {31'd0, fault_req_o}, {31'd0, e_flt});
    chk("R11 zero bits", psr_o & 32'h0EFF_FFC0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    e_flg = '0; e_exc = '0; e_t = 1'b1; e_flt = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset psr", psr_o, 32'h0100_0000);
    chk("R1 reset fault", {31'd0, fault_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", psr_o, 32'h0100_0000);

    // R3 signed overflow and unsigned carry
    step(1, 3'd0, 32'h7FFF_FFFF, 32'h1, '0, 0, 0, 0, 0, 0, 0);
    chk("R3 ovf flags", {28'd0, psr_o[31:28]}, 32'h9);
    step(1, 3'd0, 32'hFFFF_FFFF, 32'h1, '0, 0, 0, 0, 0, 0, 0);
    chk("R3 carry zero", {28'd0, psr_o[31:28]}, 32'h6);
    // R4 equal compare: Z=1, C=1 (no borrow)
    step(1, 3'd1, 32'h55, 32'h55, '0, 0, 0, 0, 0, 0, 0);
    chk("R4 equal cmp", {28'd0, psr_o[31:28]}, 32'h6);
    step(1, 3'd1, 32'h1, 32'h2, '0, 0, 0, 0, 0, 0, 0);
    chk("R4 borrow", {28'd0, psr_o[31:28]}, 32'h8);
    step(1, 3'd1, 32'h8000_0000, 32'h1, '0, 0, 0, 0, 0, 0, 0);
    chk("R4 sub ovf", {28'd0, psr_o[31:28]}, 32'h3);
    // R5 multiply keeps C,V
    step(1, 3'd2, '0, '0, 32'h0, 0, 0, 0, 0, 0, 0);
    chk("R5 mul keep CV", {28'd0, psr_o[31:28]}, 32'h7);
    // R6 shift loads C
    step(1, 3'd4, '0, '0, 32'h8000_0000, 0, 0, 0, 0, 0, 0);
    chk("R6 shift C", {28'd0, psr_o[31:28]}, 32'h9);
    // R7 reserved class
    step(1, 3'd6, '0, '0, 32'h0, 1, 0, 0, 0, 0, 0);
    chk("R7 class 6", {28'd0, psr_o[31:28]}, 32'h9);
    // R8 load together with a flag write
    step(1, 3'd3, '0, '0, 32'h0, 0, 1, 6'd63, 0, 0, 0);
    chk("R8 load 63", {26'd0, psr_o[5:0]}, 32'd63);
    step(0, 3'd0, '0, '0, '0, 0, 1, 6'd0, 0, 0, 0);
    chk("R8 thread", {26'd0, psr_o[5:0]}, 32'd0);
    // R9/R10: clear state while issuing -> no fault yet, next issue faults
    step(0, 3'd0, '0, '0, '0, 0, 0, 0, 1, 0, 1);
    chk("R10 same-cycle", {31'd0, fault_req_o}, 32'd0);
    step(0, 3'd0, '0, '0, '0, 0, 0, 0, 0, 0, 1);
    chk("R10 fault", {31'd0, fault_req_o}, 32'd1);
    step(0, 3'd0, '0, '0, '0, 0, 0, 0, 1, 1, 0);
    chk("R9 restore", {31'd0, psr_o[24]}, 32'd1);

    for (int i = 0; i < 2000; i++) begin
      logic [2:0] op;
      op = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
      step($urandom_range(0, 3) != 0, op, $urandom, ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom,
           ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom, 1'($urandom),
           $urandom_range(0, 3) == 0, 6'($urandom), $urandom_range(0, 7) == 0,
           $urandom_range(0, 2) != 0, 1'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule